// File: doc/BRIEF.md
# Blocked Interrupt Status Register Pair

This block holds two processor-readable interrupt status registers, A and B, and the single interrupt request line they drive. Bus-side logic sends one-cycle event pulses, one per status bit, and each bit has an enable mask bit. While no enabled bit is pending, an event sets its visible status bit directly. Once an enabled bit is latched, both visible registers freeze. A visible bit can then only be cleared by a read, and the registers stay frozen until the processor has read and cleared every pending enabled bit.

Events that arrive during a freeze go into a shadow holding register for each status register. They move into the visible registers in the cycle after the freeze ends. Register A bits and the address-change bit of register B use a conditional merge: a parked bit is moved over only if the latest read of that register returned the bit as zero. A parked bit that coincides with an event already reported is therefore absorbed. The other change bits of register B are parked as toggles, so an even number of changes during a freeze leaves nothing behind.

A read strobe returns the register contents in the same cycle and clears the register at the next edge. The interrupt output is a flop that holds the OR of all enabled visible bits. It also acts as the freeze flag.

Top module: `isr_pair_top`

## Requirements
- R1: After synchronous reset, both visible registers read zero and `irq` is 0.
- R2: While not frozen, an event pulse sets its visible bit at the next edge, and `irq` is 1 after that edge if the bit is enabled.
- R3: A bit whose enable is 0 is still latched in the visible register but neither raises `irq` nor freezes the registers.
- R4: `rd_x` returns the current contents on `rdata_x` in the same cycle and clears the register at the next edge. While not frozen, an event in the same cycle as the read survives the clear.
- R5: While frozen, a visible register changes only by being cleared through a read, and new events do not appear in it.
- R6: Parked events are moved into the visible registers by the edge that ends the first unfrozen cycle, which is the cycle after the read that cleared the last pending enabled bit. The holding registers are then empty.
- R7: A parked register A bit is discarded if the latest read of register A returned that bit as 1, and is moved over if it was read as 0. Before any read, a bit counts as read as 0.
- R8: The change bits of register B (every bit except bit ADDR_BIT) are parked as toggles: an odd number of events during a freeze moves a 1 across, and an even number moves nothing.
- R9: Bit ADDR_BIT of register B (default 0) follows the conditional rule of R7, using the latest read of register B.
- R10: An event that arrives while frozen, in the same cycle as a read of its register, is parked and not dropped.
- R11: `irq` is registered. One cycle after the inputs settle, it equals the OR over both registers of the visible bits ANDed with their enables.
- R12: Reset also empties the holding registers and the freeze state, so nothing parked before a reset appears after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_a | input | W_A | Event pulses for register A |
| en_a | input | W_A | Enable mask for register A |
| rd_a | input | 1 | Read strobe for register A (clears it) |
| rdata_a | output | W_A | Visible contents of register A |
| evt_b | input | W_B | Event pulses for register B |
| en_b | input | W_B | Enable mask for register B |
| rd_b | input | 1 | Read strobe for register B (clears it) |
| rdata_b | output | W_B | Visible contents of register B |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The collision of interest is a read-clear and a new event in the same cycle, both while frozen and while free. The bench provokes it by driving a read strobe together with an event on a bit that was read as 0 and on a bit that was read as 1. It judges the outcome two cycles later, after the transfer: the first bit must reappear and the second must have been absorbed. A long pseudo-random sweep over a 4+4-bit configuration then mixes events, reads and changing enables, and compares every cycle against a bit-level model computed in the bench.

// File: rtl/isr_pkg.sv
package isr_pkg;

  typedef enum logic {
    MERGE_COND   = 1'b0,
    MERGE_TOGGLE = 1'b1
  } merge_e;

  // New content of one holding bit while the registers are frozen.
  function automatic logic park_bit(merge_e kind, logic held, logic ev);
    if (kind == MERGE_TOGGLE) return held ^ ev;
    return held | ev;
  endfunction

  // Whether one held bit moves into the visible register on unfreeze.
  function automatic logic xfer_bit(merge_e kind, logic held, logic read_zero);
    if (kind == MERGE_TOGGLE) return held;
    return held & read_zero;
  endfunction

endpackage

// File: rtl/isr_slice.sv
module isr_slice #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] TOG = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         blocked,
  input  logic [W-1:0] evt,
  input  logic         rd,
  output logic [W-1:0] stat,
  output logic [W-1:0] stat_nx
);

  logic [W-1:0] stat_q;
  logic [W-1:0] hold_q;
  logic [W-1:0] rz_q;
  logic [W-1:0] hold_nx;
  logic [W-1:0] park_w;
  logic [W-1:0] xfer_w;

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam isr_pkg::merge_e KIND = TOG[i] ? isr_pkg::MERGE_TOGGLE : isr_pkg::MERGE_COND;
    assign park_w[i] = isr_pkg::park_bit(KIND, hold_q[i], evt[i]);
    assign xfer_w[i] = isr_pkg::xfer_bit(KIND, hold_q[i], rz_q[i]);
  end

  always_comb begin
    stat_nx = rd ? '0 : stat_q;
    if (!blocked) stat_nx = stat_nx | evt | xfer_w;
    hold_nx = blocked ? park_w : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      hold_q <= '0;
      rz_q   <= '1;
    end else begin
      stat_q <= stat_nx;
      hold_q <= hold_nx;
      if (rd) rz_q <= ~stat_q;
    end
  end

  assign stat = stat_q;

  // R5
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (blocked && !rd) |=> $stable(stat_q));

  // R4
  blocked_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (blocked && rd) |=> (stat_q == '0));

  // R6
  hold_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !blocked |=> (hold_q == '0));

  // R6
  xfer_land_chk: assert property (@(posedge clk) disable iff (rst)
    !blocked |=> ((stat_q & $past(xfer_w)) == $past(xfer_w)));

endmodule

// File: rtl/isr_pair_top.sv
module isr_pair_top #(
  parameter int unsigned W_A      = 8,
  parameter int unsigned W_B      = 8,
  parameter int unsigned ADDR_BIT = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W_A-1:0] evt_a,
  input  logic [W_A-1:0] en_a,
  input  logic           rd_a,
  output logic [W_A-1:0] rdata_a,
  input  logic [W_B-1:0] evt_b,
  input  logic [W_B-1:0] en_b,
  input  logic           rd_b,
  output logic [W_B-1:0] rdata_b,
  output logic           irq
);

  localparam logic [W_A-1:0] TOG_A = '0;
  localparam logic [W_B-1:0] TOG_B = ~(W_B'(1) << ADDR_BIT);

  logic           irq_q;
  logic [W_A-1:0] nx_a;
  logic [W_B-1:0] nx_b;
  logic           pend_nx;

  isr_slice #(.W(W_A), .TOG(TOG_A)) u_reg_a (
    .clk(clk), .rst(rst), .blocked(irq_q), .evt(evt_a), .rd(rd_a),
    .stat(rdata_a), .stat_nx(nx_a)
  );

  isr_slice #(.W(W_B), .TOG(TOG_B)) u_reg_b (
    .clk(clk), .rst(rst), .blocked(irq_q), .evt(evt_b), .rd(rd_b),
    .stat(rdata_b), .stat_nx(nx_b)
  );

  assign pend_nx = (|(nx_a & en_a)) | (|(nx_b & en_b));

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= pend_nx;
  end

  assign irq = irq_q;

  // R11
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(en_a) && $stable(en_b)) |->
      (irq_q == ((|(rdata_a & en_a)) | (|(rdata_b & en_b)))));

endmodule

// File: tb/test_isr_pair_top.sv
`timescale 1ns/1ps
module test_isr_pair_top;

  localparam int W = 4;
  localparam logic [W-1:0] TOGM = 4'b1110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] evt_a = '0, en_a = '1, evt_b = '0, en_b = '1;
  logic rd_a = 1'b0, rd_b = 1'b0;
  logic [W-1:0] rdata_a, rdata_b;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [W-1:0] m_sa, m_ha, m_ra, m_sb, m_hb, m_rb;
  logic m_irq;

  always #2 clk = ~clk;

  isr_pair_top #(.W_A(W), .W_B(W), .ADDR_BIT(0)) i_isr_pair_top (
    .clk(clk), .rst(rst), .evt_a(evt_a), .en_a(en_a), .rd_a(rd_a), .rdata_a(rdata_a),
    .evt_b(evt_b), .en_b(en_b), .rd_b(rd_b), .rdata_b(rdata_b), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] f_stat(logic [W-1:0] s, h, rz, e, logic rd, logic blk, logic [W-1:0] tg);
    logic [W-1:0] base = rd ? 4'h0 : s;
    if (blk) return base;
    return base | e | (h & (rz | tg));
  endfunction

  function automatic logic [W-1:0] f_hold(logic [W-1:0] h, e, logic blk, logic [W-1:0] tg);
    if (!blk) return 4'h0;
    return ((h | e) & ~tg) | ((h ^ e) & tg);
  endfunction

  task automatic model_reset();
    m_sa = '0; m_ha = '0; m_ra = '1; m_sb = '0; m_hb = '0; m_rb = '1; m_irq = 1'b0;
  endtask

  task automatic step(input logic [W-1:0] ea, input logic ra, input logic [W-1:0] eb, input logic rb, input string tag);
    logic [W-1:0] nsa, nha, nra, nsb, nhb, nrb;
    evt_a = ea; rd_a = ra; evt_b = eb; rd_b = rb;
    nsa = f_stat(m_sa, m_ha, m_ra, ea, ra, m_irq, 4'h0);
    nha = f_hold(m_ha, ea, m_irq, 4'h0);
    nra = ra ? ~m_sa : m_ra;
    nsb = f_stat(m_sb, m_hb, m_rb, eb, rb, m_irq, TOGM);
    nhb = f_hold(m_hb, eb, m_irq, TOGM);
    nrb = rb ? ~m_sb : m_rb;
    @(posedge clk);
    #1;
    m_sa = nsa; m_ha = nha; m_ra = nra; m_sb = nsb; m_hb = nhb; m_rb = nrb;
    m_irq = |((nsa & en_a) | (nsb & en_b));
    chk(rdata_a === m_sa, {tag, " model A"}, rdata_a, m_sa);
    chk(rdata_b === m_sb, {tag, " model B"}, rdata_b, m_sb);
    chk(irq === m_irq, "R11 model irq", {3'b0, irq}, {3'b0, m_irq});
    evt_a = '0; rd_a = 1'b0; evt_b = '0; rd_b = 1'b0;
  endtask

  task automatic idle(input string tag);
    step(4'h0, 1'b0, 4'h0, 1'b0, tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk);
    #1;
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    model_reset();
    do_reset();
    // R1
    chk(rdata_a == 0 && rdata_b == 0 && irq == 0, "R1 reset state", rdata_a | rdata_b, 4'h0);

    // R3: masked bits latch without interrupt
    en_a = 4'b0001;
    step(4'b0100, 0, 0, 0, "R3");
    step(4'b1000, 0, 0, 0, "R3");
    chk(rdata_a == 4'b1100 && irq == 0, "R3 masked latch", rdata_a, 4'b1100);
    // R2
    step(4'b0001, 0, 0, 0, "R2");
    chk(rdata_a == 4'b1101, "R2 enabled latch", rdata_a, 4'b1101);
    chk(irq == 1, "R2 irq raised", {3'b0, irq}, 4'h1);
    // R5: frozen
    step(4'b0010, 0, 4'b0010, 0, "R5");
    chk(rdata_a == 4'b1101 && rdata_b == 4'b0000, "R5 frozen A", rdata_a, 4'b1101);
    // R8: toggle parity, bit1 twice (back to 0), bit2 once
    step(0, 0, 4'b0110, 0, "R8");
    // R4 R10: read while frozen with concurrent event on a bit read as zero
    step(4'b0010, 1, 0, 0, "R10");
    chk(rdata_a == 4'b0000, "R4 read clears", rdata_a, 4'b0000);
    chk(irq == 0, "R4 irq drops", {3'b0, irq}, 4'h0);
    // R6: transfer in the cycle after the read
    idle("R6");
    chk(rdata_a == 4'b0010, "R10 parked event kept", rdata_a, 4'b0010);
    chk(rdata_b == 4'b0100, "R8 odd toggle moves", rdata_b, 4'b0100);
    chk(irq == 1, "R6 irq after transfer", {3'b0, irq}, 4'h1);
    step(0, 1, 0, 1, "R4");
    chk(rdata_a == 0 && rdata_b == 0, "R4 both cleared", rdata_a | rdata_b, 4'h0);

    // R7: parked A bit absorbed when read as 1
    step(4'b0001, 0, 0, 0, "R7");
    step(4'b0001, 0, 0, 0, "R7");
    step(0, 1, 0, 0, "R7");
    idle("R7");
    chk(rdata_a == 4'b0000 && irq == 0, "R7 absorbed", rdata_a, 4'b0000);

    // R9 R8: address bit absorbed, even toggles vanish
    step(0, 0, 4'b0001, 0, "R9");
    step(0, 0, 4'b0001, 0, "R9");
    step(0, 0, 4'b0010, 0, "R8");
    step(0, 0, 4'b0010, 0, "R8");
    step(0, 0, 0, 1, "R9");
    idle("R9");
    chk(rdata_b == 4'b0000, "R9/R8 absorbed and even", rdata_b, 4'b0000);

    // R9: address bit moved when last B read saw it zero
    step(0, 0, 0, 1, "R9");
    step(4'b0001, 0, 0, 0, "R9");
    step(0, 0, 4'b0001, 0, "R9");
    chk(rdata_b == 4'b0000, "R9 parked not visible", rdata_b, 4'b0000);
    step(0, 1, 0, 0, "R9");
    idle("R9");
    chk(rdata_b == 4'b0001 && irq == 1, "R9 moved", rdata_b, 4'b0001);
    step(0, 0, 0, 1, "R9");

    // R4: unfrozen read with same-cycle event survives
    en_a = 4'b0000;
    step(4'b0100, 0, 0, 0, "R4");
    step(4'b1000, 1, 0, 0, "R4");
    chk(rdata_a == 4'b1000, "R4 event beats clear", rdata_a, 4'b1000);
    step(0, 1, 0, 0, "R4");

    // R12: reset drops parked content
    en_a = 4'b0001;
    step(4'b0001, 0, 0, 0, "R12");
    step(4'b0100, 0, 4'b0010, 0, "R12");
    do_reset();
    chk(rdata_a == 0 && rdata_b == 0 && irq == 0, "R12 reset clears", rdata_a | rdata_b, 4'h0);
    idle("R12");
    chk(rdata_a == 0 && rdata_b == 0, "R12 no stale transfer", rdata_a | rdata_b, 4'h0);

    // Sweep: pseudo-random events, reads and enables against the model
    lf = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (n % 97 == 0) begin
        en_a = lf[3:0];
        en_b = lf[7:4];
      end
      step(lf[3:0] & lf[11:8], lf[4] & lf[5], lf[7:4] & lf[15:12], lf[6] & lf[9], "R2/R6 sweep");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule